// File: doc/BRIEF.md
# SPI Register-Access Target with Pointer Autoincrement

This block is a serial target that lets a host reach a map of 2^AW registers (64 by default) over a four-wire serial link. The four wires are a chip select, a serial clock, a data input and a data output with an output enable. The block samples the link with its own system clock. It drives a plain register-file port: one write strobe with an address and a data word, and a combinational read path that returns the word at the current address.

Every transaction opens with a command byte. A write command is followed by a byte that loads the address pointer. Each byte after that is stored in the next writable register at or after the pointer, and locations marked read-only in a mask parameter are stepped over. A read command is followed by data bytes that are shifted out from the pointer. The pointer advances after every data byte, wraps at the top of the map, and keeps its value between transactions. A read can therefore continue from an address that an earlier write transaction loaded without sending data.

Top module: `spi_regmap_slave`

## Requirements
- R1: While chip select is high, dout_oe is 0, and serial clock and data input activity causes no register write.
- R2: A falling chip select starts a frame. Bits are taken on rising serial clock edges, MSB first. The first byte is the command: CMD_WR (default 90h) selects write and CMD_RD (default C1h) selects read.
- R3: In a write, the second byte loads the pointer from its low AW bits. Each later byte is written to the first writable address at or after the pointer, and the pointer then becomes that address plus one, modulo 2^AW.
- R4: In a read, each byte after the command shifts out the register at the pointer, MSB first. A bit changes on falling serial clock edges, and the first bit appears on the first falling edge after the command's eighth rising edge. The pointer is incremented after each byte. Read bursts do not skip read-only locations.
- R5: The pointer wraps from the last address (3Fh by default) to 00h, in both reads and writes.
- R6: WR_MASK bit i set means address i is writable. By default addresses 4 to 7 and 3Fh are read-only, and a write never targets a read-only address.
- R7: After any other command byte, the rest of the transaction causes no write and leaves the pointer unchanged.
- R8: Chip select rising during a byte discards that partial byte, and bytes completed earlier stay committed.
- R9: The pointer resets to 0 and keeps its value across transactions.
- R10: Each stored byte produces exactly one reg_we pulse of one system clock cycle, with reg_addr and reg_wdata valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial link |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |
| dout_oe | output | 1 | Output enable for dout; 0 means high-impedance |
| reg_addr | output | AW | Register address: the write target during a strobe, otherwise the pointer |
| reg_wdata | output | DW | Write data |
| reg_we | output | 1 | Write strobe |
| reg_rdata | input | DW | Read data for reg_addr, combinational |

## Verification
The assertions assume that chip select, serial clock and data input each hold every level for at least three system clock cycles. They also assume that the serial clock is low whenever chip select changes, and that the register file returns read data in the same cycle. The bench keeps to these limits by holding every half serial clock period for eight system clocks. It changes the data input only while the serial clock is low, and it moves chip select only a half period away from any clock edge. Under these conditions the edge detectors see each serial clock transition exactly once.

// File: rtl/spi_regmap_slave.sv
module spi_regmap_slave #(
  parameter int AW = 6,
  parameter int DW = 8,
  parameter logic [7:0] CMD_WR = 8'h90,
  parameter logic [7:0] CMD_RD = 8'hC1,
  parameter logic [(2**AW)-1:0] WR_MASK = 64'h7FFF_FFFF_FFFF_FF0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          din,
  output logic          dout,
  output logic          dout_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  input  logic [DW-1:0] reg_rdata
);
  localparam int NREG = 2**AW;
  localparam int BW = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_WDATA, S_RDATA, S_IGN} state_t;

  state_t        state;
  logic [2:0]    cs_sr, sck_sr;
  logic [1:0]    din_sr;
  logic [DW-1:0] shreg, tx, wd_q;
  logic [BW-1:0] bitcnt;
  logic [AW-1:0] ptr, wa_q, tgt, idx;
  logic          tgt_ok, dout_q, we_q;

  wire cs_s     = cs_sr[1];
  wire cs_fall  = cs_sr[2] & ~cs_sr[1];
  wire sck_rise = ~sck_sr[2] & sck_sr[1];
  wire sck_fall = sck_sr[2] & ~sck_sr[1];
  wire [DW-1:0] rx = {shreg[DW-2:0], din_sr[1]};
  wire last_bit = (bitcnt == BW'(DW-1));

  assign dout      = dout_q;
  assign dout_oe   = ~cs_s;
  assign reg_we    = we_q;
  assign reg_wdata = wd_q;
  assign reg_addr  = we_q ? wa_q : ptr;

  always_comb begin
    tgt_ok = 1'b0;
    tgt    = ptr;
    idx    = '0;
    for (int k = NREG-1; k >= 0; k--) begin
      idx = ptr + AW'(k);
      if (WR_MASK[idx]) begin
        tgt_ok = 1'b1;
        tgt    = idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sr  <= 3'b111;
      sck_sr <= 3'b000;
      din_sr <= 2'b00;
      state  <= S_IDLE;
      shreg  <= '0;
      tx     <= '0;
      bitcnt <= '0;
      ptr    <= '0;
      wa_q   <= '0;
      wd_q   <= '0;
      we_q   <= 1'b0;
      dout_q <= 1'b0;
    end else begin
      cs_sr  <= {cs_sr[1:0], cs_n};
      sck_sr <= {sck_sr[1:0], sclk};
      din_sr <= {din_sr[0], din};
      we_q   <= 1'b0;
      if (cs_s) begin
        state  <= S_IDLE;
        bitcnt <= '0;
      end else if (cs_fall) begin
        state  <= S_CMD;
        bitcnt <= '0;
      end else begin
        if (sck_rise && state != S_IDLE) begin
          shreg  <= rx;
          bitcnt <= last_bit ? '0 : bitcnt + 1'b1;
          if (last_bit) begin
            case (state)
              S_CMD: begin
                if (rx == CMD_WR)      state <= S_ADDR;
                else if (rx == CMD_RD) state <= S_RDATA;
                else                   state <= S_IGN;
              end
              S_ADDR: begin
                ptr   <= rx[AW-1:0];
                state <= S_WDATA;
              end
              S_WDATA: begin
                if (tgt_ok) begin
                  we_q <= 1'b1;
                  wa_q <= tgt;
                  wd_q <= rx;
                  ptr  <= tgt + 1'b1;
                end
              end
              S_RDATA: ptr <= ptr + 1'b1;
              default: ;
            endcase
          end
        end
        if (sck_fall && state == S_RDATA) begin
          if (bitcnt == '0) begin
            dout_q <= reg_rdata[DW-1];
            tx     <= {reg_rdata[DW-2:0], 1'b0};
          end else begin
            dout_q <= tx[DW-1];
            tx     <= {tx[DW-2:0], 1'b0};
          end
        end
      end
    end
  end

  AST_IDLE_ON_CS: assert property (@(posedge clk) disable iff (!rst_n) cs_s |=> (state == S_IDLE)); // R1
  AST_WE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n) we_q |-> ($past(state) == S_WDATA)); // R10
  AST_WE_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n) we_q |-> WR_MASK[reg_addr]); // R6
  AST_PTR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) we_q |-> (ptr == AW'(wa_q + 1'b1))); // R3
  AST_IGN_PTR: assert property (@(posedge clk) disable iff (!rst_n) (state == S_IGN) |=> $stable(ptr)); // R7
  AST_IDLE_NO_BITS: assert property (@(posedge clk) disable iff (!rst_n) (state == S_IDLE) |-> (bitcnt == '0)); // R8
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) we_q |=> !we_q); // R10
endmodule

// File: tb/spi_regmap_slave_tb_top.sv
module spi_regmap_slave_tb_top;
  localparam int HALF = 8;
  localparam logic [7:0] WR = 8'h90;
  localparam logic [7:0] RD = 8'hC1;
  localparam logic [63:0] MASK = 64'h7FFF_FFFF_FFFF_FF0F;

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, din = 0;
  logic dout, dout_oe, reg_we;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [64];
  logic [7:0] exp_mem [64];
  logic [5:0] mptr;
  int errs = 0, checks = 0;
  bit done = 0;
  logic [13:0] wq [$];
  logic [7:0] rq [$];
  logic [7:0] rx_val;
  event rx_ev;

  always #10 clk = ~clk;

  spi_regmap_slave dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (reg_we) begin
    if (wq.size() == 0) check(0, "R7/R10 unexpected write", {reg_addr, reg_wdata}, 0);
    else begin
      logic [13:0] e;
      e = wq.pop_front();
      check({reg_addr, reg_wdata} == e, "R3/R6 write addr,data", {reg_addr, reg_wdata}, e);
    end
  end

  always @(rx_ev) begin
    if (rq.size() == 0) check(0, "R4 unexpected read byte", rx_val, 0);
    else begin
      logic [7:0] e;
      e = rq.pop_front();
      check(rx_val == e, "R4/R5/R9 read byte", rx_val, e);
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] b, input int n, output logic [7:0] r);
    r = 0;
    for (int i = 7; i > 7 - n; i--) begin
      din = b[i];
      wait_clk(HALF);
      r[i] = dout;
      sclk = 1;
      wait_clk(HALF);
      sclk = 0;
    end
  endtask

  task automatic cs_begin;
    cs_n = 0;
    wait_clk(HALF);
  endtask

  task automatic cs_end;
    wait_clk(HALF);
    cs_n = 1;
    wait_clk(2 * HALF);
  endtask

  function automatic logic [6:0] next_wr(input logic [5:0] p);
    for (int k = 0; k < 64; k++) if (MASK[6'(p + k)]) return {1'b1, 6'(p + k)};
    return 7'd0;
  endfunction

  task automatic do_write(input logic [5:0] a, input int n, input logic [7:0] base);
    logic [7:0] r;
    logic [6:0] t;
    cs_begin;
    spi_bits(WR, 8, r);
    spi_bits({2'b00, a}, 8, r);
    mptr = a;
    for (int j = 0; j < n; j++) begin
      logic [7:0] d;
      d = base + 8'(j * 17);
      t = next_wr(mptr);
      if (t[6]) begin
        wq.push_back({t[5:0], d});
        exp_mem[t[5:0]] = d;
        mptr = t[5:0] + 6'd1;
      end
      spi_bits(d, 8, r);
    end
    cs_end;
  endtask

  task automatic do_read(input int n);
    logic [7:0] r;
    cs_begin;
    spi_bits(RD, 8, r);
    check(dout_oe == 1, "R1 oe during frame", dout_oe, 1);
    for (int j = 0; j < n; j++) begin
      rq.push_back(exp_mem[mptr]);
      mptr = mptr + 6'd1;
      spi_bits(8'hFF, 8, r);
      rx_val = r;
      ->rx_ev;
      #1;
    end
    cs_end;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run;
  end

  initial begin
    logic [7:0] r;
    for (int i = 0; i < 64; i++) begin
      mem[i] = 8'(i * 37 + 5);
      exp_mem[i] = 8'(i * 37 + 5);
    end
    mptr = 0;
    wait_clk(5);
    rst_n = 1;
    wait_clk(5);
    check(dout_oe == 0 && reg_we == 0, "R1 reset idle", {dout_oe, reg_we}, 0);
    check(reg_addr == 0, "R9 pointer resets to 0", reg_addr, 0);

    do_write(6'h10, 3, 8'h11);   // R2 R3
    do_read(2);                   // R4 R9: continues at 13h
    do_write(6'h03, 2, 8'h44);   // R6: 03h then 08h
    do_write(6'h06, 1, 8'h99);   // R6: read-only start goes to 08h
    do_write(6'h3E, 2, 8'h66);   // R5 R6: 3Eh, skip 3Fh, 00h
    do_write(6'h3D, 0, 8'h00);   // R9: load pointer only
    do_read(4);                   // R5: 3Dh..00h wrap

    cs_begin;                     // R7 unknown command
    spi_bits(8'h55, 8, r);
    spi_bits(8'h10, 8, r);
    spi_bits(8'h77, 8, r);
    cs_end;
    do_read(1);                   // R7 pointer unchanged

    cs_begin;                     // R8 abort mid-byte
    spi_bits(WR, 8, r);
    spi_bits(8'h20, 8, r);
    wq.push_back({6'h20, 8'hA5});
    exp_mem[6'h20] = 8'hA5;
    mptr = 6'h21;
    spi_bits(8'hA5, 8, r);
    spi_bits(8'hC3, 5, r);
    cs_end;
    do_read(1);                   // R8 partial byte discarded

    din = 1;                      // R1 activity with CS high
    for (int i = 0; i < 16; i++) begin
      wait_clk(HALF); sclk = 1; wait_clk(HALF); sclk = 0;
    end
    check(dout_oe == 0, "R1 oe low while CS high", dout_oe, 0);
    do_read(1);                   // R1 pointer untouched

    wait_clk(10);
    check(wq.size() == 0, "R10 all expected writes seen", wq.size(), 0);
    check(rq.size() == 0, "R4 all expected reads seen", rq.size(), 0);
    check(mem[6'h3F] == 8'(63 * 37 + 5), "R6 read-only 3Fh untouched", mem[6'h3F], 8'(63 * 37 + 5));
    finish_run;
  end
endmodule